// File: doc/BRIEF.md
# Asynchronous DRAM Timing Controller with Refresh Arbitration

This block connects a simple request/ready processor bus to an asynchronous DRAM array. A bus command carries a module select, a read or write strobe, a full word address and write data. The controller latches the command and drops its ready output. It splits the address into a row half and a column half and drives them, one after the other, onto a shared set of DRAM address pins. It then runs the row strobe, the column strobe and the precharge gap. All of these timings are parameters counted in clock cycles.

An internal interval timer raises a refresh request. The request is granted only when no bus cycle is in progress, and it takes priority over a bus command that is waiting in the same cycle. A static parameter selects one of two refresh styles:

- **Row-strobe-only refresh.** The controller supplies the row from its own counter, which steps after each refresh.
- **Column-before-row refresh.** The column strobe leads the row strobe, and the DRAM supplies the row itself.

Read data is held in an output register until the next read completes.

Top module: `dramc_ctrl`

## Requirements
- R1: The upper half of `bus_addr` is on `dram_addr` when `dram_ras_n` falls for an access. The lower half is on `dram_addr` while `dram_cas_n` is low.
- R2: In a bus access, `dram_ras_n` falls first. `dram_cas_n` falls exactly T_RCD cycles later and stays low for T_CAS cycles. `dram_ras_n` stays low for at least T_RAS cycles. Both strobes stay high for at least T_PRE cycles before either falls again.
- R3: In a write, `dram_we_n` is low, `dram_dq_oe` is 1 and `dram_dq_out` carries the write data while `dram_cas_n` is low. In a read, `bus_rdata` takes the value of `dram_dq_in` in the last cycle of the column strobe. `dram_dq_oe` is never 1 outside a write column strobe.
- R4: With REF_MODE=0 (row-strobe-only refresh), a refresh drives `dram_ras_n` low for T_RAS cycles while `dram_cas_n` stays high. The row on `dram_addr` comes from a counter that starts at 0 after reset and increases by 1 after each refresh, wrapping.
- R5: With REF_MODE=1 (column-before-row refresh), a refresh drives `dram_cas_n` low T_RCD cycles before `dram_ras_n` falls, then holds both low for T_RAS cycles, with `dram_we_n` high.
- R6: A refresh request is raised every REF_INTERVAL cycles and stays pending until granted. A grant happens only when no cycle is running, so over an idle window of N cycles the number of refreshes is N/REF_INTERVAL plus or minus one.
- R7: When a refresh is pending, it wins over a bus command. While a bus command is held continuously for N cycles, at least N/REF_INTERVAL - 1 refreshes still occur.
- R8: `bus_ready` is 1 only when the controller is idle with no pending refresh. It is 0 whenever either strobe is low. A command is accepted at a clock edge where `bus_ready`, `bus_sel` and `bus_rd` or `bus_wr` are all 1, and `bus_ready` is 0 in the cycle after acceptance.
- R9: `bus_rdata` keeps the last read value through idle cycles and through write cycles.
- R10: A command with `bus_sel` low is ignored: no column access takes place and memory contents are unchanged.
- R11: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_dq_oe` is 0, `bus_rdata` is 0 and `bus_ready` is 1.
- R12: With REF_MODE=0, every one of the 2^(ADDR_W/2) rows is refreshed within 2^(ADDR_W/2) * REF_INTERVAL cycles plus one refresh time. The parameters are rejected at elaboration when that product exceeds RETAIN_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Module select |
| bus_rd | input | 1 | Read command (wins over write) |
| bus_wr | input | 1 | Write command |
| bus_addr | input | ADDR_W | Word address, row in upper half |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data register |
| bus_ready | output | 1 | Ready to accept a command |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_out | output | DATA_W | Data towards the DRAM |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The assertions check the following on every cycle:

- the precharge gap before any strobe falls;
- that ready is never high during a strobe;
- that the output enable appears only inside a write column strobe;
- the strobe ordering for the selected refresh style;
- that a pending refresh request is held until granted;
- the single-step advance of the refresh row counter.

Only the bench scenarios can show the remaining behaviour:

- that data written at one address returns from that address only, which proves the row/column split;
- that read data is held through idle and write cycles;
- that unselected commands leave memory unchanged;
- that refresh keeps its rate under continuous bus traffic;
- that every row is visited within the retention window.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RCD,
      ST_CAS,
      ST_HOLD,
      ST_REFA,
      ST_REFB,
      ST_PRE
   } seq_st_t;

   localparam int REF_RAS_ONLY = 0;
   localparam int REF_CBR      = 1;
endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
   parameter int REF_INTERVAL = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   output logic ref_req
);
   localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

   logic [TW-1:0] tmr_q;
   logic          tick;

   assign tick = (tmr_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q   <= TW'(REF_INTERVAL - 1);
         ref_req <= 1'b0;
      end else begin
         tmr_q <= tick ? TW'(REF_INTERVAL - 1) : tmr_q - 1'b1;
         if (tick)       ref_req <= 1'b1;
         else if (grant) ref_req <= 1'b0;
      end
   end

   // R6: a raised request stays up until the sequencer grants it
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req && !grant |=> ref_req);
   // R6: the sequencer grants only a pending request
   p_grant_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> ref_req);
endmodule

// File: rtl/dramc_row_ctr.sv
module dramc_row_ctr #(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [ROW_W-1:0] row
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    row <= '0;
      else if (step) row <= row + 1'b1;
   end

   // R4: the refresh row advances by exactly one after each refresh
   p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> row == ROW_W'($past(row) + 1'b1));
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
   import dramc_pkg::*;
#(
   parameter int ROW_W    = 8,
   parameter int DATA_W   = 16,
   parameter int T_RCD    = 2,
   parameter int T_RAS    = 5,
   parameter int T_CAS    = 2,
   parameter int T_PRE    = 3,
   parameter int REF_MODE = REF_RAS_ONLY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ROW_W-1:0]  bus_row,
   input  logic [ROW_W-1:0]  bus_col,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              ref_req,
   output logic              grant,
   output logic              ref_done,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output logic [ROW_W-1:0]  lat_row,
   output logic [ROW_W-1:0]  lat_col,
   output logic              col_phase,
   output logic              ref_phase,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   input  logic [DATA_W-1:0] dq_in
);
   localparam int HOLD  = T_RAS - T_RCD - T_CAS;
   localparam int HOLDL = (HOLD > 0) ? HOLD : 1;
   localparam int CW    = $clog2(T_RAS + T_RCD + T_CAS + T_PRE + 1);
   localparam int GW    = $clog2(T_PRE + 1);

   seq_st_t           st_q, st_d;
   logic [CW-1:0]     cnt_q, cnt_d;
   logic              wr_q, accept, ras_on, cas_on, last;
   logic [DATA_W-1:0] wd_q;
   logic [GW-1:0]     gap_q;

   function automatic logic [CW-1:0] len(input int n);
      return CW'(n - 1);
   endfunction

   assign ready  = (st_q == ST_IDLE) && !ref_req;
   assign grant  = (st_q == ST_IDLE) && ref_req;
   assign accept = ready && bus_sel && (bus_rd || bus_wr);
   assign last   = (cnt_q == '0);

   always_comb begin
      st_d  = st_q;
      cnt_d = last ? cnt_q : cnt_q - 1'b1;
      unique case (st_q)
         ST_IDLE:
            if (grant) begin
               st_d  = ST_REFA;
               cnt_d = (REF_MODE == REF_CBR) ? len(T_RCD) : len(T_RAS);
            end else if (accept) begin
               st_d  = ST_RCD;
               cnt_d = len(T_RCD);
            end
         ST_RCD:
            if (last) begin
               st_d  = ST_CAS;
               cnt_d = len(T_CAS);
            end
         ST_CAS:
            if (last) begin
               if (HOLD > 0) begin
                  st_d  = ST_HOLD;
                  cnt_d = len(HOLDL);
               end else begin
                  st_d  = ST_PRE;
                  cnt_d = len(T_PRE);
               end
            end
         ST_HOLD:
            if (last) begin
               st_d  = ST_PRE;
               cnt_d = len(T_PRE);
            end
         ST_REFA:
            if (last) begin
               if (REF_MODE == REF_CBR) begin
                  st_d  = ST_REFB;
                  cnt_d = len(T_RAS);
               end else begin
                  st_d  = ST_PRE;
                  cnt_d = len(T_PRE);
               end
            end
         ST_REFB:
            if (last) begin
               st_d  = ST_PRE;
               cnt_d = len(T_PRE);
            end
         ST_PRE:
            if (last) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      ras_on = (st_q inside {ST_RCD, ST_CAS, ST_HOLD, ST_REFB}) ||
               (st_q == ST_REFA && REF_MODE == REF_RAS_ONLY);
      cas_on = (st_q inside {ST_CAS, ST_REFB}) ||
               (st_q == ST_REFA && REF_MODE == REF_CBR);
   end

   assign ras_n     = !ras_on;
   assign cas_n     = !cas_on;
   assign we_n      = !(st_q == ST_CAS && wr_q);
   assign dq_oe     = (st_q == ST_CAS) && wr_q;
   assign dq_out    = wd_q;
   assign col_phase = (st_q == ST_CAS);
   assign ref_phase = (st_q inside {ST_REFA, ST_REFB});
   assign ref_done  = last && ((st_q == ST_REFA && REF_MODE == REF_RAS_ONLY) ||
                               st_q == ST_REFB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         wr_q    <= 1'b0;
         wd_q    <= '0;
         lat_row <= '0;
         lat_col <= '0;
         rdata   <= '0;
         gap_q   <= GW'(T_PRE);
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         if (accept) begin
            wr_q    <= bus_wr && !bus_rd;
            wd_q    <= bus_wdata;
            lat_row <= bus_row;
            lat_col <= bus_col;
         end
         if (st_q == ST_CAS && last && !wr_q) rdata <= dq_in;
         if (ras_n && cas_n) gap_q <= (gap_q == GW'(T_PRE)) ? gap_q : gap_q + 1'b1;
         else                gap_q <= '0;
      end
   end

   // R8: ready never coincides with an active strobe
   p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> ras_n && cas_n);
   // R2: a strobe may fall only after the full precharge gap
   p_pre_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) && $past(ras_n && cas_n) |-> gap_q >= GW'(T_PRE));
   // R3: data is driven only inside a write column strobe
   p_oe_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !we_n && !ras_n && !cas_n);

   generate
      if (REF_MODE == REF_RAS_ONLY) begin : g_chk_ro
         // R4: row-strobe-only refresh never asserts the column strobe
         p_ro_no_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ref_phase |-> cas_n);
         // R2: the column strobe only falls under an already low row strobe
         p_cas_after_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cas_n) |-> !ras_n && $past(!ras_n));
      end else begin : g_chk_cbr
         // R5: refresh row strobe falls under an already low column strobe
         p_cbr_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ras_n) && ref_phase |-> !cas_n && $past(!cas_n));
         // R5: refresh leaves write enable inactive
         p_cbr_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ref_phase |-> we_n);
      end
   endgenerate
endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
   import dramc_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int T_RCD        = 2,
   parameter int T_RAS        = 5,
   parameter int T_CAS        = 2,
   parameter int T_PRE        = 3,
   parameter int REF_INTERVAL = 780,
   parameter int RETAIN_CYC   = 200000,
   parameter int REF_MODE     = REF_RAS_ONLY
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_ready,
   output logic [ADDR_W/2-1:0] dram_addr,
   output logic                dram_ras_n,
   output logic                dram_cas_n,
   output logic                dram_we_n,
   output logic                dram_dq_oe,
   output logic [DATA_W-1:0]   dram_dq_out,
   input  logic [DATA_W-1:0]   dram_dq_in
);
   localparam int ROW_W = ADDR_W / 2;
   localparam int ROWS  = 1 << ROW_W;

   initial begin
      assert (ADDR_W % 2 == 0 && ADDR_W >= 2) else $error("ADDR_W must be even");
      assert (T_RCD >= 1 && T_CAS >= 1 && T_PRE >= 1) else $error("timings must be at least 1");
      assert (T_RAS >= T_RCD + T_CAS) else $error("T_RAS must cover T_RCD + T_CAS");
      assert (REF_INTERVAL >= 2) else $error("REF_INTERVAL too small");
      assert (REF_MODE == REF_RAS_ONLY || REF_MODE == REF_CBR) else $error("bad REF_MODE");
      // R12: all rows must fit inside the retention window
      assert (longint'(ROWS) * REF_INTERVAL <= longint'(RETAIN_CYC))
         else $error("refresh interval misses retention window");
   end

   logic             ref_req, grant, ref_done, col_phase, ref_phase;
   logic [ROW_W-1:0] lat_row, lat_col;

   dramc_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_tmr (
      .clk(clk), .rst_n(rst_n), .grant(grant), .ref_req(ref_req));

   dramc_seq #(
      .ROW_W(ROW_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_CAS(T_CAS), .T_PRE(T_PRE), .REF_MODE(REF_MODE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_row(bus_addr[ADDR_W-1:ROW_W]), .bus_col(bus_addr[ROW_W-1:0]),
      .bus_wdata(bus_wdata),
      .ref_req(ref_req), .grant(grant), .ref_done(ref_done),
      .ready(bus_ready), .rdata(bus_rdata),
      .lat_row(lat_row), .lat_col(lat_col),
      .col_phase(col_phase), .ref_phase(ref_phase),
      .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
      .dq_oe(dram_dq_oe), .dq_out(dram_dq_out), .dq_in(dram_dq_in));

   generate
      if (REF_MODE == REF_RAS_ONLY) begin : g_ro
         logic [ROW_W-1:0] ref_row;
         dramc_row_ctr #(.ROW_W(ROW_W)) u_rctr (
            .clk(clk), .rst_n(rst_n), .step(ref_done), .row(ref_row));
         assign dram_addr = col_phase ? lat_col : (ref_phase ? ref_row : lat_row);
      end else begin : g_cbr
         logic unused_ref;
         assign unused_ref = ref_done ^ ref_phase;
         assign dram_addr  = col_phase ? lat_col : lat_row;
      end
   endgenerate
endmodule

// File: tb/sim_dramc_ctrl.sv
module sim_dramc_ctrl;
   localparam int AW = 8, DW = 16, RW = 4;
   localparam int TRCD = 2, TRAS = 6, TCAS = 2, TPRE = 3, REFI = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          sel [2], rd [2], wr [2];
   logic [AW-1:0] addr_b [2];
   logic [DW-1:0] wd_b [2], rdat [2], dqo [2], dqi [2];
   logic          rdy [2], ras_w [2], cas_w [2], we_w [2], oe_w [2];
   logic [RW-1:0] da [2];

   int errors = 0, checks = 0;
   bit done = 0;
   logic [DW-1:0] exp_mem [2][256];

   dramc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RCD(TRCD), .T_RAS(TRAS), .T_CAS(TCAS),
      .T_PRE(TPRE), .REF_INTERVAL(REFI), .RETAIN_CYC(1000), .REF_MODE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel[0]), .bus_rd(rd[0]), .bus_wr(wr[0]),
      .bus_addr(addr_b[0]), .bus_wdata(wd_b[0]), .bus_rdata(rdat[0]), .bus_ready(rdy[0]),
      .dram_addr(da[0]), .dram_ras_n(ras_w[0]), .dram_cas_n(cas_w[0]), .dram_we_n(we_w[0]),
      .dram_dq_oe(oe_w[0]), .dram_dq_out(dqo[0]), .dram_dq_in(dqi[0]));

   dramc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RCD(TRCD), .T_RAS(TRAS), .T_CAS(TCAS),
      .T_PRE(TPRE), .REF_INTERVAL(REFI), .RETAIN_CYC(1000), .REF_MODE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel[1]), .bus_rd(rd[1]), .bus_wr(wr[1]),
      .bus_addr(addr_b[1]), .bus_wdata(wd_b[1]), .bus_rdata(rdat[1]), .bus_ready(rdy[1]),
      .dram_addr(da[1]), .dram_ras_n(ras_w[1]), .dram_cas_n(cas_w[1]), .dram_we_n(we_w[1]),
      .dram_dq_oe(oe_w[1]), .dram_dq_out(dqo[1]), .dram_dq_in(dqi[1]));

   // behavioural DRAM and strobe monitor, one per controller
   for (genvar k = 0; k < 2; k++) begin : mon
      logic [DW-1:0] mem [256];
      logic [RW-1:0] row_q = '0, exp_row = '0;
      logic [15:0]   seen = '0;
      bit prev_r = 1, prev_c = 1, saw_cas = 0, cbr = 0;
      int rlen = 0, clen = 0, gap = 100;
      int nro = 0, ncbr = 0, nrd = 0, nwr = 0;
      int v_ord = 0, v_wid = 0, v_pre = 0, v_rdy = 0, v_oe = 0, v_seq = 0;
      int last_acc = -1;

      initial for (int i = 0; i < 256; i++) mem[i] = '0;
      assign dqi[k] = mem[{row_q, da[k]}];

      always @(posedge clk) begin
         if (rst_n) begin
            if (prev_r && prev_c && (!ras_w[k] || !cas_w[k]) && gap < TPRE) v_pre++;
            if ((!ras_w[k] || !cas_w[k]) && rdy[k]) v_rdy++;
            if (oe_w[k] && !(!ras_w[k] && !cas_w[k] && !we_w[k] && !cbr)) v_oe++;
            if (!ras_w[k]) rlen++;
            if (!cas_w[k]) clen++;
            if (prev_r && !ras_w[k]) begin
               rlen = 1;
               saw_cas = !cas_w[k];
               if (!cas_w[k]) begin
                  if (!cbr || clen < TRCD + 1) v_ord++;
               end else row_q = da[k];
            end
            if (prev_c && !cas_w[k]) begin
               clen = 1;
               if (!ras_w[k]) begin
                  saw_cas = 1;
                  if (rlen != TRCD + 1) v_ord++;
                  last_acc = {row_q, da[k]};
                  if (!we_w[k]) begin
                     if (!oe_w[k]) v_oe++;
                     mem[{row_q, da[k]}] = dqo[k];
                     nwr++;
                  end else nrd++;
               end else if (k == 0) v_ord++;
               else cbr = 1;
            end
            if (!prev_c && cas_w[k] && !cbr && clen != TCAS) v_wid++;
            if (!prev_r && ras_w[k]) begin
               if (rlen < TRAS) v_wid++;
               if (cbr) ncbr++;
               else if (!saw_cas) begin
                  nro++;
                  seen[row_q] = 1'b1;
                  if (row_q != exp_row) v_seq++;
                  exp_row = row_q + 1'b1;
               end
            end
            if (cbr && cas_w[k] && ras_w[k]) cbr = 0;
            if (ras_w[k] && cas_w[k]) gap++; else gap = 0;
            prev_r = ras_w[k];
            prev_c = cas_w[k];
         end
      end
   end

   function automatic int refs(input int k);
      return (k == 0) ? mon[0].nro + mon[0].ncbr : mon[1].nro + mon[1].ncbr;
   endfunction
   function automatic int writes(input int k);
      return (k == 0) ? mon[0].nwr : mon[1].nwr;
   endfunction
   function automatic int lastacc(input int k);
      return (k == 0) ? mon[0].last_acc : mon[1].last_acc;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_op(input int k, input bit w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] q);
      @(negedge clk);
      sel[k] = 1; rd[k] = !w; wr[k] = w; addr_b[k] = a; wd_b[k] = d;
      while (!rdy[k]) @(negedge clk);
      @(negedge clk);
      sel[k] = 0; rd[k] = 0; wr[k] = 0;
      while (!rdy[k]) @(negedge clk);
      q = rdat[k];
      if (w) exp_mem[k][a] = d;
   endtask

   task automatic t_reset();
      for (int k = 0; k < 2; k++) begin
         chk(rdy[k] === 1'b1, "R11 ready", int'(rdy[k]), 1);
         chk(ras_w[k] === 1'b1 && cas_w[k] === 1'b1 && we_w[k] === 1'b1, "R11 strobes",
             int'({ras_w[k], cas_w[k], we_w[k]}), 7);
         chk(oe_w[k] === 1'b0 && rdat[k] === '0, "R11 oe/rdata", int'(rdat[k]), 0);
      end
   endtask

   task automatic t_rw(input int k);
      logic [AW-1:0] al [6] = '{8'h00, 8'hFF, 8'h12, 8'h13, 8'h21, 8'h31};
      logic [DW-1:0] q;
      for (int i = 0; i < 6; i++) begin
         bus_op(k, 1, al[i], {al[i], ~al[i]} ^ DW'(k * 16'h0F0F), q);
         chk(lastacc(k) == int'(al[i]), "R1 write address split", lastacc(k), int'(al[i]));
      end
      for (int i = 5; i >= 0; i--) begin
         bus_op(k, 0, al[i], '0, q);
         chk(lastacc(k) == int'(al[i]), "R1 read address split", lastacc(k), int'(al[i]));
         chk(q == exp_mem[k][al[i]], "R3 read data", int'(q), int'(exp_mem[k][al[i]]));
      end
      bus_op(k, 1, 8'h12, 16'hBEEF, q);
      bus_op(k, 0, 8'h13, '0, q);
      chk(q == exp_mem[k][8'h13], "R1 neighbour column untouched", int'(q), int'(exp_mem[k][8'h13]));
      bus_op(k, 0, 8'h12, '0, q);
      chk(q == 16'hBEEF, "R3 overwrite", int'(q), 16'hBEEF);
   endtask

   task automatic t_hold(input int k);
      logic [DW-1:0] q, q2;
      bus_op(k, 0, 8'hFF, '0, q);
      repeat (20) @(negedge clk);
      chk(rdat[k] == q, "R9 held while idle", int'(rdat[k]), int'(q));
      bus_op(k, 1, 8'h44, 16'h1234, q2);
      chk(rdat[k] == q, "R9 held across write", int'(rdat[k]), int'(q));
   endtask

   task automatic t_accept(input int k);
      logic [DW-1:0] q;
      @(negedge clk);
      while (!rdy[k]) @(negedge clk);
      sel[k] = 1; rd[k] = 1; addr_b[k] = 8'h21;
      @(negedge clk);
      chk(rdy[k] == 1'b0, "R8 ready drops after accept", int'(rdy[k]), 0);
      sel[k] = 0; rd[k] = 0;
      while (!rdy[k]) @(negedge clk);
      chk(rdat[k] == exp_mem[k][8'h21], "R8 read completes", int'(rdat[k]), int'(exp_mem[k][8'h21]));
      bus_op(k, 0, 8'h00, '0, q);
   endtask

   task automatic t_nosel(input int k);
      logic [DW-1:0] q;
      int w0;
      w0 = writes(k);
      @(negedge clk);
      sel[k] = 0; wr[k] = 1; addr_b[k] = 8'h31; wd_b[k] = 16'hDEAD;
      repeat (30) @(negedge clk);
      wr[k] = 0;
      chk(writes(k) == w0, "R10 no column access", writes(k), w0);
      bus_op(k, 0, 8'h31, '0, q);
      chk(q == exp_mem[k][8'h31], "R10 memory unchanged", int'(q), int'(exp_mem[k][8'h31]));
   endtask

   task automatic t_rate(input int k);
      int r0, d;
      r0 = refs(k);
      repeat (400) @(negedge clk);
      d = refs(k) - r0;
      chk(d >= 9 && d <= 11, "R6 idle refresh rate", d, 10);
   endtask

   task automatic t_starve(input int k);
      int r0, d;
      r0 = refs(k);
      @(negedge clk);
      sel[k] = 1; rd[k] = 1; addr_b[k] = 8'h12;
      repeat (600) @(negedge clk);
      sel[k] = 0; rd[k] = 0;
      while (!rdy[k]) @(negedge clk);
      d = refs(k) - r0;
      chk(d >= 600 / REFI - 1, "R7 refresh under continuous traffic", d, 600 / REFI - 1);
   endtask

   task automatic t_retain();
      mon[0].seen = '0;
      repeat (16 * REFI + 2 * TRAS + 2 * TPRE) @(negedge clk);
      chk(mon[0].seen == 16'hFFFF, "R12 all rows refreshed", int'(mon[0].seen), 16'hFFFF);
   endtask

   task automatic t_final();
      for (int k = 0; k < 2; k++) begin
         int vo, vw, vp, vr, ve;
         vo = (k == 0) ? mon[0].v_ord : mon[1].v_ord;
         vw = (k == 0) ? mon[0].v_wid : mon[1].v_wid;
         vp = (k == 0) ? mon[0].v_pre : mon[1].v_pre;
         vr = (k == 0) ? mon[0].v_rdy : mon[1].v_rdy;
         ve = (k == 0) ? mon[0].v_oe  : mon[1].v_oe;
         chk(vo == 0, (k == 0) ? "R2 strobe order" : "R5 strobe order", vo, 0);
         chk(vw == 0, "R2 strobe widths", vw, 0);
         chk(vp == 0, "R2 precharge gap", vp, 0);
         chk(vr == 0, "R8 ready during strobe", vr, 0);
         chk(ve == 0, "R3 output enable window", ve, 0);
      end
      chk(mon[0].v_seq == 0, "R4 refresh row sequence", mon[0].v_seq, 0);
      chk(mon[0].ncbr == 0 && mon[0].nro > 0, "R4 row-strobe-only mode", mon[0].ncbr, 0);
      chk(mon[1].nro == 0 && mon[1].ncbr > 0, "R5 column-first mode", mon[1].nro, 0);
   endtask

   initial begin
      for (int k = 0; k < 2; k++) begin
         sel[k] = 0; rd[k] = 0; wr[k] = 0; addr_b[k] = '0; wd_b[k] = '0;
         for (int i = 0; i < 256; i++) exp_mem[k][i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      for (int k = 0; k < 2; k++) begin
         t_rw(k);
         t_hold(k);
         t_accept(k);
         t_nosel(k);
         t_rate(k);
         t_starve(k);
      end
      t_retain();
      t_final();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule